// File: doc/BRIEF.md
# Exception Context Frame Writer

When an exception is accepted, this block stores the interrupted context to memory as a fixed frame of eight words. On a one-cycle start request it latches the current stack pointer together with the eight register values to be saved: four argument registers, the scratch register R12, the link register, the return program counter and the status word. It then issues one word-wide write per accepted valid/ready handshake. The stack is descending, so the frame ends up in the 32 bytes directly below the incoming stack pointer. The lowest address of the frame becomes the new stack pointer.

Writes run from the top of the frame downward, so the status word goes out first and R0 goes out last. One cycle after the final write is accepted, the block raises a one-cycle completion pulse and presents the lowered stack pointer. It keeps that stack pointer on its output until the next frame completes. A start request that arrives before the block is idle again has no effect. The exception sequencer around the block handles unstacking, selection between stack pointers and vector fetch.

Top module: `exc_frame_pusher`

## Requirements
- R1: After synchronous reset, `mem_valid_o` and `done_o` are 0 and `sp_o` is 0.
- R2: When `start_i` is high at a clock edge while idle, `mem_valid_o` is 1 in the next cycle, with `mem_addr_o` = `sp_i` − 4 and `mem_data_o` = `psr_i`, both taken at that edge.
- R3: Each write accepted while `mem_valid_o` and `mem_ready_i` are both high is followed in the next cycle by the next word at an address 4 lower. With N = `sp_i` − 0x20, the words are placed as follows: PSR at N+0x1C, PC at N+0x18, LR at N+0x14, R12 at N+0x10, R3 at N+0x0C, R2 at N+0x08, R1 at N+0x04 and R0 at N+0x00. The write order is PSR, PC, LR, R12, R3, R2, R1, R0.
- R4: While `mem_valid_o` is 1 and `mem_ready_i` is 0, `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold their values into the next cycle.
- R5: `done_o` is 1 for exactly the one cycle after the eighth write is accepted. In that cycle `sp_o` equals N. `sp_o` keeps that value until the next frame completes.
- R6: Register values and the stack pointer are sampled only at the accepting start edge. Input changes after that edge do not alter the addresses or data written.
- R7: `start_i` is ignored while a frame is being written and in the `done_o` cycle. It causes no restart and no extra write.
- R8: Address arithmetic wraps modulo 2^ADDR_W, for example when `sp_i` is below 0x20.
- R9: `mem_valid_o` is 0 when idle and in the `done_o` cycle. `mem_valid_o` and `done_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to save a context frame |
| sp_i | input | ADDR_W | Stack pointer before the exception |
| r0_i | input | DATA_W | R0 value to save |
| r1_i | input | DATA_W | R1 value to save |
| r2_i | input | DATA_W | R2 value to save |
| r3_i | input | DATA_W | R3 value to save |
| r12_i | input | DATA_W | R12 value to save |
| lr_i | input | DATA_W | Link register value to save |
| pc_i | input | DATA_W | Return program counter to save |
| psr_i | input | DATA_W | Status word to save |
| mem_valid_o | output | 1 | Write request valid |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_addr_o | output | ADDR_W | Byte address of the write |
| mem_data_o | output | DATA_W | Word to write |
| sp_o | output | ADDR_W | Stack pointer after the frame is stored |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the following on every cycle:
- the first write presented after an accepted start;
- the 4-byte downward step after each accepted write;
- stability of the write request under backpressure;
- the single-cycle completion pulse and its stack pointer, which equals the last write address;
- valid and done never being high together.

Only the bench's scenarios can show the following:
- that the full eight-word order pairs each register with its offset;
- that values are frozen at the start edge while the inputs keep changing;
- that start requests arriving during a frame or in its completion cycle produce no extra writes;
- that the address arithmetic wraps at a low stack pointer.

// File: rtl/efp_pkg.sv
package efp_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int WORD_BYTES  = 4;
  localparam int IDX_W       = $clog2(FRAME_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/efp_frame_regs.sv
// Holds the eight captured context words; slot k is the word stored at
// byte offset 4*k above the new stack pointer.
module efp_frame_regs
  import efp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] words_i [FRAME_WORDS],
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [FRAME_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < FRAME_WORDS; k++) slot_q[k] <= '0;
    end else if (cap_en_i) begin
      for (int k = 0; k < FRAME_WORDS; k++) slot_q[k] <= words_i[k];
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/efp_seq.sv
// Frame sequencer: accepts start when idle, counts the slot index down
// on each handshake, and produces the completion pulse and new SP.
module efp_seq
  import efp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              hs_i,
  output logic              accept_o,
  output logic              step_o,
  output logic              finish_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME_WORDS * WORD_BYTES);
  localparam logic [IDX_W-1:0]  TOP_IDX     = IDX_W'(FRAME_WORDS - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              last;

  assign last     = (idx_q == '0);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_PUSH) && hs_i && !last;
  assign finish_o = (state_q == ST_PUSH) && hs_i && last;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      done_o  <= 1'b0;
      sp_o    <= '0;
    end else begin
      done_o <= finish_o;
      if (finish_o) sp_o <= base_q;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PUSH;
          idx_q   <= TOP_IDX;
          base_q  <= sp_i - FRAME_BYTES;
        end
        ST_PUSH: if (hs_i) begin
          if (last) state_q <= ST_DONE;
          else      idx_q   <= idx_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: a stalled frame keeps its place regardless of start_i
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PUSH && !hs_i) |=> (state_q == ST_PUSH && idx_q == $past(idx_q)));
endmodule

// File: rtl/efp_wport.sv
// Registered write port: presents the current address/data pair.
module efp_wport
  import efp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              step_i,
  input  logic              finish_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] first_data_i,
  input  logic [DATA_W-1:0] next_data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (accept_i) begin
      valid_o <= 1'b1;
      addr_o  <= sp_i - STEP;
      data_o  <= first_data_i;
    end else if (step_i) begin
      addr_o  <= addr_o - STEP;
      data_o  <= next_data_i;
    end else if (finish_i) begin
      valid_o <= 1'b0;
    end
  end

  // R3: each non-final acceptance moves down by one word
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (valid_o && addr_o == $past(addr_o) - STEP));
endmodule

// File: rtl/exc_frame_pusher.sv
module exc_frame_pusher
  import efp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] r0_i,
  input  logic [DATA_W-1:0] r1_i,
  input  logic [DATA_W-1:0] r2_i,
  input  logic [DATA_W-1:0] r3_i,
  input  logic [DATA_W-1:0] r12_i,
  input  logic [DATA_W-1:0] lr_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] psr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              done_o
);
  logic [DATA_W-1:0] frame_words [FRAME_WORDS];
  logic              hs, accept, step, finish;
  logic [IDX_W-1:0]  idx, rd_idx;
  logic [DATA_W-1:0] rd_data;

  // slot order is the memory layout: slot k sits at new SP + 4*k
  assign frame_words[0] = r0_i;
  assign frame_words[1] = r1_i;
  assign frame_words[2] = r2_i;
  assign frame_words[3] = r3_i;
  assign frame_words[4] = r12_i;
  assign frame_words[5] = lr_i;
  assign frame_words[6] = pc_i;
  assign frame_words[7] = psr_i;

  assign hs     = mem_valid_o && mem_ready_i;
  assign rd_idx = idx - 1'b1;

  efp_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sp_i(sp_i), .hs_i(hs),
    .accept_o(accept), .step_o(step), .finish_o(finish), .idx_o(idx),
    .done_o(done_o), .sp_o(sp_o)
  );

  efp_frame_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .cap_en_i(accept), .words_i(frame_words),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  efp_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wport_i (
    .clk(clk), .rst(rst), .accept_i(accept), .step_i(step), .finish_i(finish),
    .sp_i(sp_i), .first_data_i(psr_i), .next_data_i(rd_data),
    .valid_o(mem_valid_o), .addr_o(mem_addr_o), .data_o(mem_data_o)
  );

  // R2: first write is the status word just below the old stack pointer
  p_first_write_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_valid_o && mem_addr_o == $past(sp_i) - ADDR_W'(WORD_BYTES)
                && mem_data_o == $past(psr_i)));

  // R4: request held under backpressure
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  // R5: completion follows the last write; new SP is the last write address
  p_done_sp_r5: assert property (@(posedge clk) disable iff (rst)
    finish |=> (done_o && sp_o == $past(mem_addr_o)));

  // R9: valid and done are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid_o && done_o));
endmodule

// File: tb/exc_frame_pusher_tb_top.sv
module exc_frame_pusher_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] sp_i = '0;
  logic [31:0] r0_i = '0, r1_i = '0, r2_i = '0, r3_i = '0;
  logic [31:0] r12_i = '0, lr_i = '0, pc_i = '0, psr_i = '0;
  logic        mem_ready_i = 1'b0;
  logic        mem_valid_o, done_o;
  logic [31:0] mem_addr_o, mem_data_o, sp_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  exc_frame_pusher #(.ADDR_W(32), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sp_i(sp_i),
    .r0_i(r0_i), .r1_i(r1_i), .r2_i(r2_i), .r3_i(r3_i),
    .r12_i(r12_i), .lr_i(lr_i), .pc_i(pc_i), .psr_i(psr_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .sp_o(sp_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=%0d cycles expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] sp, input int k);
    return sp - 32'h20 + 32'(4 * k);
  endfunction

  task automatic drive_words(input logic [31:0] w [8]);
    r0_i = w[0]; r1_i = w[1]; r2_i = w[2]; r3_i = w[3];
    r12_i = w[4]; lr_i = w[5]; pc_i = w[6]; psr_i = w[7];
  endtask

  task automatic scramble();
    sp_i = $urandom; r0_i = $urandom; r1_i = $urandom; r2_i = $urandom;
    r3_i = $urandom; r12_i = $urandom; lr_i = $urandom; pc_i = $urandom;
    psr_i = $urandom;
  endtask

  // w[k] is the word expected at new SP + 4*k (0=R0 .. 7=PSR)
  task automatic run_frame(input logic [31:0] sp, input logic [31:0] w [8],
                           input int rdy_pct, input bit noise, input bit start_in_done);
    logic [31:0] held_a, held_d;
    bit stalled = 1'b0;
    int k = 7;
    @(negedge clk);
    start_i = 1'b1; sp_i = sp; drive_words(w);
    @(negedge clk);
    start_i = 1'b0;
    chk(mem_valid_o == 1'b1, "R2", "valid after start", 32'(mem_valid_o), 32'd1);
    chk(mem_addr_o == sp - 32'd4, "R2", "first addr", mem_addr_o, sp - 32'd4);
    while (k >= 0) begin
      if (noise) begin
        scramble();                           // R6: inputs change mid-frame
        start_i = (($urandom % 4) == 0);      // R7: start while busy
      end
      mem_ready_i = (($urandom % 100) < 32'(rdy_pct));
      if (stalled) begin
        chk(mem_addr_o == held_a, "R4", "addr held", mem_addr_o, held_a);
        chk(mem_data_o == held_d, "R4", "data held", mem_data_o, held_d);
      end
      chk(mem_valid_o == 1'b1, "R3", "valid mid-frame", 32'(mem_valid_o), 32'd1);
      if (mem_ready_i) begin
        chk(mem_addr_o == exp_addr(sp, k), "R3", "addr", mem_addr_o, exp_addr(sp, k));
        chk(mem_data_o == w[k], "R3/R6", "data", mem_data_o, w[k]);
        k--;
        stalled = 1'b0;
      end else begin
        held_a = mem_addr_o; held_d = mem_data_o; stalled = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0; mem_ready_i = 1'b0;
    chk(done_o == 1'b1, "R5", "done pulse", 32'(done_o), 32'd1);
    chk(sp_o == sp - 32'h20, "R5", "new sp", sp_o, sp - 32'h20);
    chk(mem_valid_o == 1'b0, "R9", "valid in done cycle", 32'(mem_valid_o), 32'd0);
    if (start_in_done) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R5", "done falls", 32'(done_o), 32'd0);
    chk(mem_valid_o == 1'b0, "R7", "no extra frame", 32'(mem_valid_o), 32'd0);
    chk(sp_o == sp - 32'h20, "R5", "sp held", sp_o, sp - 32'h20);
  endtask

  initial begin
    logic [31:0] w [8];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(mem_valid_o == 1'b0, "R1", "reset valid", 32'(mem_valid_o), 32'd0);
    chk(done_o == 1'b0, "R1", "reset done", 32'(done_o), 32'd0);
    chk(sp_o == 32'd0, "R1", "reset sp", sp_o, 32'd0);

    // directed: full-rate ready, distinct words
    for (int k = 0; k < 8; k++) w[k] = 32'hA000_0000 + 32'(k);
    run_frame(32'h2000_0100, w, 100, 1'b0, 1'b0);
    // directed: heavy backpressure (R4)
    for (int k = 0; k < 8; k++) w[k] = 32'h5A5A_0000 ^ 32'(k * 17);
    run_frame(32'h2000_0400, w, 15, 1'b0, 1'b0);
    // directed: low stack pointer wraps (R8)
    for (int k = 0; k < 8; k++) w[k] = $urandom;
    run_frame(32'h0000_0010, w, 100, 1'b0, 1'b0);
    chk(sp_o == 32'hFFFF_FFF0, "R8", "wrapped sp", sp_o, 32'hFFFF_FFF0);
    // directed: start during done cycle is ignored (R7)
    for (int k = 0; k < 8; k++) w[k] = $urandom;
    run_frame(32'h1000_0000, w, 60, 1'b1, 1'b1);

    // random frames with noise on inputs and start
    for (int f = 0; f < 40; f++) begin
      for (int k = 0; k < 8; k++) w[k] = $urandom;
      run_frame($urandom, w, 20 + int'($urandom % 81), 1'b1, ($urandom % 2) == 1);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule